// File: doc/BRIEF.md
# Radix-8 Sign-Magnitude Signed Multiplier

This block multiplies two N-bit two's-complement operands and returns their full 2N-bit two's-complement product. It is purely combinational, so the product follows the operands in the same cycle. N is a parameter and may be 8, 16, 32 or 64.

The operands are first reduced to unsigned N-bit magnitudes. The product sign is the XOR of the two operand sign bits. A small bank derives the three odd multiples of the multiplicand magnitude that a shift cannot form: three, five and seven times. The multiplier magnitude is cut into unsigned 3-bit digits, starting at the least significant end. The top digit is zero-filled when N is not a multiple of three. Each digit drives one multiplexer, and the digit codes act as that multiplexer's named selections:

- `DIG_ZERO` (0) selects zero.
- `DIG_ONE` (1) selects X.
- `DIG_TWO` (2) selects X shifted left by 1.
- `DIG_THREE` (3) selects the precomputed 3X.
- `DIG_FOUR` (4) selects X shifted left by 2.
- `DIG_FIVE` (5) selects the precomputed 5X.
- `DIG_SIX` (6) selects the precomputed 3X shifted left by 1.
- `DIG_SEVEN` (7) selects the precomputed 7X.

There is no stored state and there are no transitions. The selected partial products, each shifted left by three bits per digit position, are added into an unsigned magnitude product. That sum is then conditionally negated with an XOR-and-increment stage.

Top module: `r8_sm_multiplier`

## Requirements
- R1: `product` equals the two's-complement product of `mcand` and `mplier`, taken as signed N-bit values, over all 2N bits, in the same cycle the operands are applied.
- R2: An operand equal to the most negative value, -2^(N-1), gives the exact product. For example, min times min gives +2^(2N-2), and min times -1 gives +2^(N-1).
- R3: When either operand is zero, `product` is zero, whatever the sign of the other operand.
- R4: When the product is nonzero, bit 2N-1 of `product` equals the XOR of bit N-1 of `mcand` and bit N-1 of `mplier`.
- R5: Multiplying by +1 returns the other operand sign-extended to 2N bits. Multiplying by -1 returns its two's-complement negation.
- R6: A multiplier digit of value 6 (octal digit 6 in the magnitude) contributes six times the multiplicand magnitude at its position.
- R7: Multiplier digits of value 3, 5 and 7 contribute three, five and seven times the multiplicand magnitude at their positions.
- R8: When N is not a multiple of three, the most significant digit is zero-extended, and a multiplier of maximum positive value (2^(N-1)-1) still gives the exact product.
- R9: The same source gives exact products when instantiated with N = 8, 16, 32 and 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand | input | N | Multiplicand, two's complement |
| mplier | input | N | Multiplier, two's complement |
| product | output | 2N | Signed product, two's complement |

## Verification
Every result of this block is due in the same cycle as its operands, with zero register stages between an input change and `product`. The bench therefore applies a new operand pair just after a rising clock edge. It reads `product` at the following falling edge, when the combinational paths have long settled, and never at the edge where the inputs move. The 8-bit instance is swept over all operand pairs. The 16-, 32- and 64-bit instances see directed corners, digit patterns and seeded random pairs on the same schedule.

// File: rtl/r8_mul_pkg.sv
package r8_mul_pkg;

    localparam int unsigned DIGIT_W    = 3;
    localparam int unsigned MULT_GUARD = 3;

    typedef enum logic [DIGIT_W-1:0] {
        DIG_ZERO  = 3'd0,
        DIG_ONE   = 3'd1,
        DIG_TWO   = 3'd2,
        DIG_THREE = 3'd3,
        DIG_FOUR  = 3'd4,
        DIG_FIVE  = 3'd5,
        DIG_SIX   = 3'd6,
        DIG_SEVEN = 3'd7
    } r8_digit_e;

    function automatic int unsigned digit_count(input int unsigned width);
        return (width + DIGIT_W - 1) / DIGIT_W;
    endfunction

endpackage

// File: rtl/r8_magnitude.sv
module r8_magnitude #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] val,
    output logic [N-1:0] mag,
    output logic         neg
);
    localparam logic [N-1:0] MAG_MAX = {1'b1, {(N-1){1'b0}}};

    assign neg = val[N-1];

    // conditional two's-complement negate, N bits unsigned result
    always_comb begin
        mag = (val ^ {N{neg}}) + N'(neg);
    end

    always_comb begin
        // R2: the most negative input still fits as an unsigned magnitude
        a_r2_mag_bound: assert (mag <= MAG_MAX)
            else $error("magnitude exceeds 2^(N-1)");
        // R3: a zero operand yields a zero magnitude
        a_r3_zero_mag: assert ((val != '0) || (mag == '0))
            else $error("zero operand gave nonzero magnitude");
    end

endmodule

// File: rtl/r8_odd_multiples.sv
module r8_odd_multiples #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0]   x,
    output logic [N+2:0]   x3,
    output logic [N+2:0]   x5,
    output logic [N+2:0]   x7
);
    localparam int unsigned MW = N + r8_mul_pkg::MULT_GUARD;

    logic [MW-1:0] x_w;
    logic [MW-1:0] x_sh1;
    logic [MW-1:0] x_sh2;
    logic [MW-1:0] x_sh3;

    assign x_w   = {3'b000, x};
    assign x_sh1 = {2'b00, x, 1'b0};
    assign x_sh2 = {1'b0, x, 2'b00};
    assign x_sh3 = {x, 3'b000};

    assign x3 = x_sh1 + x_w;
    assign x5 = x_sh2 + x_w;
    assign x7 = x_sh3 - x_w;

    always_comb begin
        // R7: multiples are consistent with each other, no guard-bit overflow
        a_r7_five_from_three: assert (x5 == x3 + x_sh1)
            else $error("5X does not equal 3X + 2X");
        a_r7_seven_from_five: assert (x7 == x5 + x_sh1)
            else $error("7X does not equal 5X + 2X");
    end

endmodule

// File: rtl/r8_digit_mux.sv
module r8_digit_mux #(
    parameter int unsigned N = 16
) (
    input  logic [2:0]   digit,
    input  logic [N-1:0] x,
    input  logic [N+2:0] x3,
    input  logic [N+2:0] x5,
    input  logic [N+2:0] x7,
    output logic [N+2:0] pp
);
    import r8_mul_pkg::*;

    r8_digit_e code;
    assign code = r8_digit_e'(digit);

    always_comb begin
        unique case (code)
            DIG_ZERO:  pp = '0;
            DIG_ONE:   pp = {3'b000, x};
            DIG_TWO:   pp = {2'b00, x, 1'b0};
            DIG_THREE: pp = x3;
            DIG_FOUR:  pp = {1'b0, x, 2'b00};
            DIG_FIVE:  pp = x5;
            DIG_SIX:   pp = {x3[N+1:0], 1'b0};
            DIG_SEVEN: pp = x7;
        endcase
    end

    always_comb begin
        // R6: no selected multiple exceeds 7X
        a_r6_pp_bound: assert (pp <= x7)
            else $error("partial product above 7X");
        // R7: low bit of d*X is the product of the low bits
        a_r7_pp_parity: assert (pp[0] == (digit[0] & x[0]))
            else $error("partial product parity mismatch");
    end

endmodule

// File: rtl/r8_partial_sum.sv
module r8_partial_sum #(
    parameter int unsigned N      = 16,
    parameter int unsigned DIGITS = 6
) (
    input  logic [DIGITS-1:0][N+2:0] pps,
    input  logic                     neg,
    output logic [2*N-1:0]           result
);
    localparam int unsigned PW = 2 * N;

    logic [PW-1:0] acc [DIGITS+1];
    logic [PW-1:0] mag_total;

    assign acc[0] = '0;

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_acc
        logic [PW-1:0] shifted;
        assign shifted     = PW'(pps[gi]) << (3 * gi);
        assign acc[gi + 1] = acc[gi] + shifted;
    end

    assign mag_total = acc[DIGITS];

    // sign restore: XOR with the sign, then add it back in
    assign result = (mag_total ^ {PW{neg}}) + PW'(neg);

    always_comb begin
        // R4: a nonzero result carries the combined sign in its MSB
        a_r4_sign_follows: assert ((mag_total == '0) || (result[PW-1] == neg))
            else $error("result sign differs from operand sign XOR");
        // R3: a zero magnitude stays zero after sign restore
        a_r3_zero_result: assert ((mag_total != '0) || (result == '0))
            else $error("zero magnitude produced nonzero result");
    end

endmodule

// File: rtl/r8_sm_multiplier.sv
module r8_sm_multiplier #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic [2*N-1:0] product
);
    import r8_mul_pkg::*;

    localparam int unsigned DIGITS = digit_count(N);
    localparam int unsigned PADW   = DIGITS * DIGIT_W;
    localparam int unsigned MW     = N + MULT_GUARD;

    logic [N-1:0]   mag_a;
    logic [N-1:0]   mag_b;
    logic           neg_a;
    logic           neg_b;
    logic           neg_p;
    logic [PADW-1:0] b_pad;
    logic [MW-1:0]  x3;
    logic [MW-1:0]  x5;
    logic [MW-1:0]  x7;
    logic [DIGITS-1:0][MW-1:0] pps;

    r8_magnitude #(.N(N)) u_mag_a (
        .val (mcand),
        .mag (mag_a),
        .neg (neg_a)
    );

    r8_magnitude #(.N(N)) u_mag_b (
        .val (mplier),
        .mag (mag_b),
        .neg (neg_b)
    );

    assign neg_p = neg_a ^ neg_b;
    assign b_pad = PADW'(mag_b);

    r8_odd_multiples #(.N(N)) u_odd (
        .x  (mag_a),
        .x3 (x3),
        .x5 (x5),
        .x7 (x7)
    );

    for (genvar gd = 0; gd < DIGITS; gd++) begin : g_digit
        r8_digit_mux #(.N(N)) u_sel (
            .digit (b_pad[DIGIT_W*gd +: DIGIT_W]),
            .x     (mag_a),
            .x3    (x3),
            .x5    (x5),
            .x7    (x7),
            .pp    (pps[gd])
        );
    end

    r8_partial_sum #(.N(N), .DIGITS(DIGITS)) u_sum (
        .pps    (pps),
        .neg    (neg_p),
        .result (product)
    );

    always_comb begin
        // R3: a zero operand at the ports forces a zero product
        a_r3_zero_operand: assert (((mcand != '0) && (mplier != '0)) || (product == '0))
            else $error("zero operand gave nonzero product");
        // R5: multiplying by +1 returns the sign-extended multiplicand
        a_r5_unit_mplier: assert ((mplier != N'(1)) ||
                                  (product == {{N{mcand[N-1]}}, mcand}))
            else $error("product by one mismatch");
    end

endmodule

// File: tb/r8_sm_multiplier_bench.sv
module r8_sm_multiplier_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;

    logic [7:0]   a8,  b8;   logic [15:0]  p8;
    logic [15:0]  a16, b16;  logic [31:0]  p16;
    logic [31:0]  a32, b32;  logic [63:0]  p32;
    logic [63:0]  a64, b64;  logic [127:0] p64;

    r8_sm_multiplier #(.N(8))  u_r8_sm_multiplier     (.mcand(a8),  .mplier(b8),  .product(p8));
    r8_sm_multiplier #(.N(16)) u_r8_sm_multiplier_w16 (.mcand(a16), .mplier(b16), .product(p16));
    r8_sm_multiplier #(.N(32)) u_r8_sm_multiplier_w32 (.mcand(a32), .mplier(b32), .product(p32));
    r8_sm_multiplier #(.N(64)) u_r8_sm_multiplier_w64 (.mcand(a64), .mplier(b64), .product(p64));

    function automatic logic [127:0] ref_mul(input logic signed [63:0] x,
                                             input logic signed [63:0] y);
        logic signed [127:0] ex;
        logic signed [127:0] ey;
        ex = x;
        ey = y;
        return ex * ey;
    endfunction

    function automatic logic [63:0] pos_mask(input int n);
        return (n == 64) ? 64'h7FFF_FFFF_FFFF_FFFF : ((64'd1 << (n - 1)) - 64'd1);
    endfunction

    function automatic logic [63:0] full_mask(input int n);
        return (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
    endfunction

    // 0: zero, 1: +1, 2: -1, 3: max positive, 4: most negative
    function automatic logic [63:0] corner(input int k, input int n);
        case (k)
            0:       return 64'd0;
            1:       return 64'd1;
            2:       return full_mask(n);
            3:       return pos_mask(n);
            default: return 64'd1 << (n - 1);
        endcase
    endfunction

    function automatic logic [63:0] rep_digit(input int d, input int n);
        logic [63:0] v;
        v = '0;
        for (int i = 0; i < 22; i++) v = v | (64'(d) << (3 * i));
        return v & pos_mask(n);
    endfunction

    task automatic set_ops(input int n, input logic [63:0] x, input logic [63:0] y);
        case (n)
            8:       begin a8  = x[7:0];  b8  = y[7:0];  end
            16:      begin a16 = x[15:0]; b16 = y[15:0]; end
            32:      begin a32 = x[31:0]; b32 = y[31:0]; end
            default: begin a64 = x;       b64 = y;       end
        endcase
    endtask

    task automatic check_width(input int n, input string tag, input bit sign_chk);
        logic signed [63:0] sx;
        logic signed [63:0] sy;
        logic [127:0] got;
        logic [127:0] exp;
        logic [127:0] mask;
        case (n)
            8:       begin sx = $signed(a8);  sy = $signed(b8);  got = 128'(p8);  end
            16:      begin sx = $signed(a16); sy = $signed(b16); got = 128'(p16); end
            32:      begin sx = $signed(a32); sy = $signed(b32); got = 128'(p32); end
            default: begin sx = $signed(a64); sy = $signed(b64); got = p64;       end
        endcase
        mask = (n == 64) ? '1 : ((128'd1 << (2 * n)) - 128'd1);
        exp  = ref_mul(sx, sy) & mask;
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s N=%0d a=%h b=%h actual=%h expected=%h", tag, n, sx, sy, got, exp);
        end
        if (sign_chk && exp != '0) begin
            total++;
            if (got[2*n-1] !== (sx[63] ^ sy[63])) begin
                bad++;
                $display("FAIL R4 N=%0d a=%h b=%h actual_sign=%0b expected_sign=%0b",
                         n, sx, sy, got[2*n-1], sx[63] ^ sy[63]);
            end
        end
    endtask

    task automatic run_one(input int n, input logic [63:0] x, input logic [63:0] y,
                           input string tag);
        @(posedge clk);
        set_ops(n, x, y);
        @(negedge clk);
        check_width(n, tag, 1'b1);
    endtask

    initial begin
        int widths [4];
        widths = '{8, 16, 32, 64};
        void'($urandom(32'd4242));
        a8 = '0; b8 = '0; a16 = '0; b16 = '0;
        a32 = '0; b32 = '0; a64 = '0; b64 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R3: zero operands at start give zero product at every width
        for (int w = 0; w < 4; w++) check_width(widths[w], "R3", 1'b0);
        rst_n = 1'b1;

        // corner pairs: R3 zero, R2 most negative, R5 unit, R1 others
        for (int w = 0; w < 4; w++) begin
            for (int kx = 0; kx < 5; kx++) begin
                for (int ky = 0; ky < 5; ky++) begin
                    string tag;
                    if (kx == 0 || ky == 0)      tag = "R3";
                    else if (kx == 4 || ky == 4) tag = "R2";
                    else if (kx < 3 || ky < 3)   tag = "R5";
                    else                         tag = "R1";
                    run_one(widths[w], corner(kx, widths[w]), corner(ky, widths[w]), tag);
                end
            end
        end

        // digit patterns: R6 for digit 6, R7 for digits 3, 5 and 7
        for (int w = 0; w < 4; w++) begin
            int n;
            n = widths[w];
            for (int d = 3; d < 8; d++) begin
                if (d != 4) begin
                    logic [63:0] bv;
                    string tag;
                    bv  = rep_digit(d, n);
                    tag = (d == 6) ? "R6" : "R7";
                    run_one(n, {$urandom, $urandom}, bv, tag);
                    run_one(n, corner(4, n), bv, tag);
                    run_one(n, {$urandom, $urandom}, (~bv + 64'd1), tag);
                    run_one(n, corner(2, n), bv, tag);
                end
            end
        end

        // R8: maximum positive multiplier with a partial top digit
        for (int w = 0; w < 4; w++) begin
            for (int r = 0; r < 6; r++) begin
                run_one(widths[w], {$urandom, $urandom}, pos_mask(widths[w]), "R8");
            end
            run_one(widths[w], corner(4, widths[w]), pos_mask(widths[w]), "R8");
        end

        // R1: all 8-bit operand pairs; R9: random pairs at wider widths
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                @(posedge clk);
                a8  = 8'(i);
                b8  = 8'(j);
                a16 = 16'($urandom); b16 = 16'($urandom);
                a32 = $urandom;      b32 = $urandom;
                a64 = {$urandom, $urandom};
                b64 = {$urandom, $urandom};
                @(negedge clk);
                check_width(8,  "R1", 1'b1);
                check_width(16, "R9", 1'b1);
                check_width(32, "R9", 1'b1);
                check_width(64, "R9", 1'b1);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule